// File: doc/BRIEF.md
# Edge-Triggered Counter Capture with Noise Filter

This block samples an external capture pin and snapshots the value of a free-running counter when a chosen edge arrives there. The pin goes through a two-stage synchronizer first. An optional digital filter then suppresses short pulses. The filter output moves only after the pin has held one level for four consecutive samples, so a filtered capture lands four clock cycles later than an unfiltered one.

Each capture loads the counter value into the capture register and raises a capture flag. Software clears the flag with a one-cycle clear strobe, or the interrupt controller clears it with an acknowledge pulse. The interrupt request is the flag gated by a local enable and a global enable. When the capture register is used as the counter's TOP value, the pin has no effect. In that mode the flag is raised by a "counter at TOP" indication from the counter instead.

Top module: `input_capture_unit`

## Requirements
- R1: While reset is asserted and right after it, `cap_value` is 0, `cap_flag` is 0 and `irq` is 0. Synchronizer, filter and edge-history state reset to low.
- R2: With `filt_en`=0, suppose a qualifying pin change is first sampled at clock edge k. The capture then takes place at edge k+2: the flag is still 0 after edge k+1 and is 1 after edge k+2.
- R3: With `filt_en`=1, the same change is captured at edge k+6, four cycles later than in R2. The filter output changes only after four consecutive synchronized samples agree.
- R4: With `filt_en`=1, a pin pulse lasting three clock cycles causes no capture. A pulse of four cycles is accepted.
- R5: `edge_rise`=1 selects rising edges and `edge_rise`=0 selects falling edges. An edge of the other polarity causes no capture, and no two capture events occur in consecutive cycles.
- R6: On a capture, `cap_value` takes the `count_val` present at the capturing edge, and `cap_flag` becomes 1.
- R7: With `top_mode`=1, pin edges neither change `cap_value` nor set the flag. A high `cnt_at_top` sets `cap_flag` at the next edge.
- R8: `flag_clr`=1 or `irq_ack`=1 clears `cap_flag` at the next edge when no set occurs in the same cycle.
- R9: If a set and a clear request fall in the same cycle, `cap_flag` is 1 afterwards.
- R10: `irq` is high exactly when `cap_flag`, `irq_en` and `gie` are all 1, with no added register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | External capture pin, asynchronous |
| count_val | input | CW (16) | Current counter value |
| cnt_at_top | input | 1 | Counter has reached TOP this cycle |
| filt_en | input | 1 | Enable the four-sample noise filter |
| edge_rise | input | 1 | 1 selects rising edges, 0 selects falling edges |
| top_mode | input | 1 | Capture register serves as counter TOP; pin ignored |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_ack | input | 1 | Interrupt serviced pulse, clears the flag |
| irq_en | input | 1 | Local interrupt enable |
| gie | input | 1 | Global interrupt enable |
| cap_value | output | CW (16) | Captured counter value |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is the clear-versus-set collision. The clear strobe has to land in exactly the cycle when a delayed, synchronized edge turns into a capture. The stimulus counts edges from the pin change and raises `flag_clr` in the cycle before edge k+2. The filter boundary is reached by holding the pin for exactly three and then exactly four cycles. A behavioural model that runs alongside the design is compared with every output after each clock.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;
  // Configuration bundle handed to the capture core.
  typedef struct packed {
    logic filt_en;
    logic edge_rise;
    logic top_mode;
  } cap_cfg_t;
endpackage

// File: rtl/cap_pin_sync.sv
`timescale 1ns/1ps
module cap_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = STAGES'({chain_q, d});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cap_noise_filter.sv
`timescale 1ns/1ps
module cap_noise_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int HW = LEN - 1;

  logic [HW-1:0] hist_q;
  logic [HW-1:0] hist_d;
  logic          all_same;
  logic          q_d;

  // hist_q[0] holds the previous sample; the current input completes the window.
  always_comb begin
    hist_d   = HW'({hist_q, d});
    all_same = (hist_q == {HW{d}});
    q_d      = all_same ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      q      <= 1'b0;
    end else begin
      hist_q <= hist_d;
      q      <= q_d;
    end
  end

  // R3: the output may only move after a full window of agreeing samples.
  p_filter_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q != $past(q)) |-> $past(all_same));
endmodule

// File: rtl/cap_capture_core.sv
`timescale 1ns/1ps
module cap_capture_core
  import cap_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl,
  input  cap_cfg_t      cfg,
  input  logic [CW-1:0] count_val,
  input  logic          cnt_at_top,
  input  logic          flag_clr,
  input  logic          irq_ack,
  output logic [CW-1:0] cap_reg,
  output logic          cap_flag
);
  logic          prev_q;
  logic          cap_event;
  logic          load_en;
  logic          cap_set;
  logic          flag_d;
  logic [CW-1:0] cap_d;

  always_comb begin
    cap_event = cfg.edge_rise ? (lvl & ~prev_q) : (~lvl & prev_q);
    load_en   = cap_event & ~cfg.top_mode;
    cap_set   = cfg.top_mode ? cnt_at_top : cap_event;
    cap_d     = count_val;
    if (cap_set)                 flag_d = 1'b1;
    else if (flag_clr | irq_ack) flag_d = 1'b0;
    else                         flag_d = cap_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      cap_flag <= 1'b0;
    end else begin
      prev_q   <= lvl;
      cap_flag <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_reg <= '0;
    else if (load_en) cap_reg <= cap_d;
  end

  p_top_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.top_mode |=> $stable(cap_reg));
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_set |=> cap_flag);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_set && (flag_clr || irq_ack)) |=> !cap_flag);
  p_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event |=> !cap_event);
endmodule

// File: rtl/input_capture_unit.sv
`timescale 1ns/1ps
module input_capture_unit
  import cap_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_pin,
  input  logic [CW-1:0] count_val,
  input  logic          cnt_at_top,
  input  logic          filt_en,
  input  logic          edge_rise,
  input  logic          top_mode,
  input  logic          flag_clr,
  input  logic          irq_ack,
  input  logic          irq_en,
  input  logic          gie,
  output logic [CW-1:0] cap_value,
  output logic          cap_flag,
  output logic          irq
);
  logic     pin_s;
  logic     pin_f;
  logic     lvl;
  cap_cfg_t cfg;

  cap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cap_pin), .q(pin_s)
  );

  cap_noise_filter #(.LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .d(pin_s), .q(pin_f)
  );

  always_comb begin
    cfg.filt_en   = filt_en;
    cfg.edge_rise = edge_rise;
    cfg.top_mode  = top_mode;
    lvl           = cfg.filt_en ? pin_f : pin_s;
  end

  cap_capture_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .cfg(cfg),
    .count_val(count_val), .cnt_at_top(cnt_at_top),
    .flag_clr(flag_clr), .irq_ack(irq_ack),
    .cap_reg(cap_value), .cap_flag(cap_flag)
  );

  assign irq = cap_flag & irq_en & gie;
endmodule

// File: tb/input_capture_unit_test.sv
`timescale 1ns/1ps
module input_capture_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_pin = 1'b0, cnt_at_top = 1'b0, filt_en = 1'b0, edge_rise = 1'b1;
  logic top_mode = 1'b0, flag_clr = 1'b0, irq_ack = 1'b0, irq_en = 1'b0, gie = 1'b0;
  logic [15:0] cnt;
  logic [15:0] cap_value;
  logic cap_flag, irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= 16'h0100;
    else        cnt <= cnt + 16'd1;

  input_capture_unit uut (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .count_val(cnt),
    .cnt_at_top(cnt_at_top), .filt_en(filt_en), .edge_rise(edge_rise),
    .top_mode(top_mode), .flag_clr(flag_clr), .irq_ack(irq_ack),
    .irq_en(irq_en), .gie(gie), .cap_value(cap_value), .cap_flag(cap_flag), .irq(irq)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: sample history kept in queues.
  bit syncq[$];
  bit histq[$];
  bit m_filt, m_prev, m_flag;
  logic [15:0] m_cap;
  bit s_now, same, lv, ev, st;

  always @(posedge clk) begin
    if (!rst_n) begin
      syncq = '{0, 0}; histq = '{0, 0, 0};
      m_filt = 0; m_prev = 0; m_flag = 0; m_cap = 16'h0;
    end else begin
      s_now = syncq[1];
      same = 1;
      foreach (histq[i]) if (histq[i] != s_now) same = 0;
      lv = filt_en ? m_filt : s_now;
      ev = edge_rise ? (lv && !m_prev) : (!lv && m_prev);
      st = top_mode ? cnt_at_top : ev;
      if (ev && !top_mode) m_cap = cnt;
      if (st) m_flag = 1;
      else if (flag_clr || irq_ack) m_flag = 0;
      m_prev = lv;
      if (same) m_filt = s_now;
      histq.push_front(s_now); void'(histq.pop_back());
      syncq.push_front(cap_pin); void'(syncq.pop_back());
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R6 model cap_value", cap_value, m_cap);
      chk("R8 model cap_flag", cap_flag, m_flag);
      chk("R10 model irq", irq, m_flag && irq_en && gie);
    end
  end

  task automatic nxt(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] c0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset cap_value", cap_value, 0);
    chk("R1 reset cap_flag", cap_flag, 0);
    chk("R1 reset irq", irq, 0);
    @(negedge clk); rst_n = 1'b1;
    nxt(4);
    chk("R1 after release flag", cap_flag, 0);

    // R2 / R6: unfiltered rising capture at edge k+2
    @(negedge clk); cap_pin = 1'b1; c0 = cnt;
    nxt(2); chk("R2 flag not early", cap_flag, 0);
    nxt(1); chk("R2 flag set at k+2", cap_flag, 1);
    chk("R6 captured count", cap_value, c0 + 16'd2);

    // R10 gating
    chk("R10 irq off without enables", irq, 0);
    @(negedge clk); irq_en = 1'b1; #1; chk("R10 irq off without gie", irq, 0);
    @(negedge clk); gie = 1'b1; #1; chk("R10 irq on", irq, 1);

    // R8 clear by strobe
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0; #1; chk("R8 clear strobe", cap_flag, 0);
    chk("R10 irq follows flag", irq, 0);

    // R5 falling edge ignored with rising select, then captured with falling select
    @(negedge clk); cap_pin = 1'b0;
    nxt(6); chk("R5 falling ignored", cap_flag, 0);
    @(negedge clk); edge_rise = 1'b0; cap_pin = 1'b1;
    nxt(6); chk("R5 rising ignored when falling selected", cap_flag, 0);
    @(negedge clk); cap_pin = 1'b0; c0 = cnt;
    nxt(3); chk("R5 falling captured flag", cap_flag, 1);
    chk("R5 falling captured value", cap_value, c0 + 16'd2);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0; #1; chk("R8 clear by ack", cap_flag, 0);

    // R3: filtered rising capture at edge k+6
    @(negedge clk); edge_rise = 1'b1; filt_en = 1'b1;
    nxt(6);
    @(negedge clk); cap_pin = 1'b1; c0 = cnt;
    nxt(6); chk("R3 filtered not early", cap_flag, 0);
    nxt(1); chk("R3 filtered flag", cap_flag, 1);
    chk("R3 filtered value", cap_value, c0 + 16'd6);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;

    // R4: three-cycle low pulse rejected, four-cycle pulse accepted
    @(negedge clk); edge_rise = 1'b0; c0 = cap_value;
    @(negedge clk); cap_pin = 1'b0;
    nxt(3); cap_pin = 1'b1;
    nxt(12); chk("R4 short pulse flag", cap_flag, 0);
    chk("R4 short pulse value", cap_value, c0);
    @(negedge clk); cap_pin = 1'b0; c0 = cnt;
    nxt(4); cap_pin = 1'b1;
    nxt(10); chk("R4 four-cycle pulse flag", cap_flag, 1);
    chk("R4 four-cycle pulse value", cap_value, c0 + 16'd6);

    // R9: clear collides with a new capture (flag already set)
    @(negedge clk); filt_en = 1'b0; edge_rise = 1'b1; cap_pin = 1'b0;
    nxt(4);
    chk("R9 precondition flag", cap_flag, 1);
    @(negedge clk); cap_pin = 1'b1; c0 = cnt;
    @(negedge clk);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0; #1;
    chk("R9 set wins", cap_flag, 1);
    chk("R9 value", cap_value, c0 + 16'd2);

    // R7: TOP mode
    @(negedge clk); top_mode = 1'b1; flag_clr = 1'b1; c0 = cap_value;
    @(negedge clk); flag_clr = 1'b0; cap_pin = 1'b0;
    nxt(4); cap_pin = 1'b1;
    nxt(6); chk("R7 pin ignored flag", cap_flag, 0);
    chk("R7 pin ignored value", cap_value, c0);
    @(negedge clk); cnt_at_top = 1'b1;
    @(negedge clk); cnt_at_top = 1'b0; #1;
    chk("R7 top sets flag", cap_flag, 1);
    chk("R7 value held", cap_value, c0);
    nxt(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule